// File: doc/BRIEF.md
# DDR Sub-Channel Performance Counter Unit

This block sits beside one sub-channel of a DDR memory controller and counts what happens on it. Single-cycle strobes arrive from the host command side (read, write, read-modify-write), from the access path (one strobe per data access, tagged with its rank and bank group) and from the error logic (one strobe line per uncorrectable-error retry type). A fixed bank of counters collects them: a 64-bit free-running cycle counter, eight bandwidth counters, ten retry counters and sixteen general event counters whose event is chosen per counter.

Every bandwidth count stands for one 64-byte transfer, so software turns a count into bytes by multiplying by 64 and divides by the cycle count to get bandwidth. The bandwidth group works in one of two modes: per bank group within one chosen rank, or per rank using the lowest four counters only. A simple word-addressed register port, with combinational read data, configures the block, starts and stops counting, clears it and reads it out.

Top module: `ddr_subch_perf_mon`

## Requirements
- R1: After reset the control word, the event-select word, all three overflow words and every counter, including the cycle counter, read zero.
- R2: While the enable bit (bit 0 of the control word, address 0x00) is set, the cycle counter advances by exactly one per clock; its low half reads at 0x01.
- R3: A read strobe at address 0x01 copies the upper 32 bits of the cycle counter into a shadow word in that cycle; address 0x02 returns the shadow word, so a low-then-high read pair is consistent even if the low half wraps between the two reads.
- R4: With the mode bit (control bit 1) clear, an access strobe whose rank equals the selected rank (control bits 5:4) increments bandwidth counter N, where N is the access bank group; accesses to other ranks are not counted. Bandwidth counter N reads at 0x10+N.
- R5: With the mode bit set, an access strobe to rank R increments bandwidth counter R (R in 0..3), and bandwidth counters 4..7 do not change.
- R6: Retry strobe line K increments retry counter K only (K in 0..9, read at 0x20+K); several lines may strobe in one cycle.
- R7: Event counter J (read at 0x30+J) counts the event named by bits 2J+1:2J of the select word at 0x06: 0 nothing, 1 host read, 2 host write, 3 host read-modify-write.
- R8: While the enable bit is clear, no counter changes, whatever strobes arrive.
- R9: Writing the control word with bit 31 set zeroes every counter at the next clock edge, winning over any strobe in the same cycle; bit 31 is not stored and the other control bits take the written value.
- R10: Counters are 32 bits and wrap from all ones to zero; the wrap sets a sticky per-counter flag (bandwidth flags at 0x03, retry at 0x04, event at 0x05, bit N for counter N), cleared by writing one to its bit; a wrap in the same cycle as that clear leaves the flag set.
- R11: A write to a counter address loads the written value into that counter; writes to 0x01 and 0x02 load the low and high halves of the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | One-cycle strobe per 64-byte data access |
| acc_rank_i | input | 2 | Rank of the access |
| acc_bg_i | input | 3 | Bank group of the access |
| retry_i | input | 10 | One-cycle strobe per uncorrectable-error retry type |
| host_rd_i | input | 1 | Host read command strobe |
| host_wr_i | input | 1 | Host write command strobe |
| host_rmw_i | input | 1 | Host read-modify-write command strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, same cycle |

## Verification
Two pairs of functions can meet in one cycle: the clear bit against an event strobe, and a write-one flag clear against the wrap that would set the same flag. The bench provokes both by driving the register write and the strobe in the same clock, then reads the counter back as zero and the flag back as set. It also loads the cycle counter just below a low-half wrap to show that the shadowed high half keeps the value seen at the low read.

// File: rtl/ddr_pm_pkg.sv
package ddr_pm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CYC_LO = 8'h01;
  localparam logic [ADDR_W-1:0] A_CYC_HI = 8'h02;
  localparam logic [ADDR_W-1:0] A_OVF_BW = 8'h03;
  localparam logic [ADDR_W-1:0] A_OVF_RT = 8'h04;
  localparam logic [ADDR_W-1:0] A_OVF_EV = 8'h05;
  localparam logic [ADDR_W-1:0] A_EVSEL  = 8'h06;
  localparam int A_BW_BASE = 'h10;
  localparam int A_RT_BASE = 'h20;
  localparam int A_EV_BASE = 'h30;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_RSEL = 4;
  localparam int CTRL_CLR  = 31;

  typedef enum logic [1:0] {
    EV_OFF      = 2'd0,
    EV_HOST_RD  = 2'd1,
    EV_HOST_WR  = 2'd2,
    EV_HOST_RMW = 2'd3
  } ev_sel_e;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = inc_i && !clr_i && !ld_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // set beats write-one-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_wrap_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !ld_i && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pm_cycle.sv
module pm_cycle #(
  parameter int CYC_W = 64,
  parameter int DW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic [DW-1:0]       ld_val_i,
  input  logic                latch_i,
  output logic [CYC_W-1:0]    cyc_o,
  output logic [CYC_W-DW-1:0] shadow_o
);
  localparam int HW = CYC_W - DW;

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [HW-1:0]    shadow_q;

  always_comb begin
    cyc_d = cyc_q + CYC_W'(en_i);
    if (ld_lo_i) cyc_d[DW-1:0]    = ld_val_i;
    if (ld_hi_i) cyc_d[CYC_W-1:DW] = ld_val_i[HW-1:0];
    if (clr_i)   cyc_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (latch_i) shadow_q <= cyc_q[CYC_W-1:DW];
  end

  assign cyc_o    = cyc_q;
  assign shadow_o = shadow_q;

  assert_cycle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !ld_lo_i && !ld_hi_i) |=> (cyc_q == $past(cyc_q) + 1'b1));
  assert_shadow_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (shadow_q == $past(cyc_q[CYC_W-1:DW])));
  assert_cycle_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cyc_q == '0));
endmodule

// File: rtl/pm_route.sv
module pm_route
  import ddr_pm_pkg::*;
#(
  parameter int RANK_W    = 2,
  parameter int BG_W      = 3,
  parameter int NUM_RETRY = 10,
  parameter int NUM_EVT   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    rank_mode_i,
  input  logic [RANK_W-1:0]       rank_sel_i,
  input  logic                    acc_i,
  input  logic [RANK_W-1:0]       acc_rank_i,
  input  logic [BG_W-1:0]         acc_bg_i,
  input  logic [NUM_RETRY-1:0]    retry_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic                    rmw_i,
  input  logic [2*NUM_EVT-1:0]    evsel_i,
  output logic [(1<<BG_W)-1:0]    inc_bw_o,
  output logic [NUM_RETRY-1:0]    inc_rt_o,
  output logic [NUM_EVT-1:0]      inc_ev_o
);
  localparam int NUM_BW   = 1 << BG_W;
  localparam int NUM_RANK = 1 << RANK_W;

  for (genvar g = 0; g < NUM_BW; g++) begin : g_bw
    logic bg_hit, rk_hit;
    assign bg_hit = acc_i && !rank_mode_i && (acc_rank_i == rank_sel_i) &&
                    (acc_bg_i == BG_W'(g));
    if (g < NUM_RANK) begin : g_rk
      assign rk_hit = acc_i && rank_mode_i && (acc_rank_i == RANK_W'(g));
    end else begin : g_nork
      assign rk_hit = 1'b0;
    end
    assign inc_bw_o[g] = en_i && (bg_hit || rk_hit);
  end

  assign inc_rt_o = retry_i & {NUM_RETRY{en_i}};

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ev
    ev_sel_e sel;
    logic    hit;
    assign sel = ev_sel_e'(evsel_i[2*e +: 2]);
    always_comb begin
      unique case (sel)
        EV_HOST_RD:  hit = rd_i;
        EV_HOST_WR:  hit = wr_i;
        EV_HOST_RMW: hit = rmw_i;
        default:     hit = 1'b0;
      endcase
    end
    assign inc_ev_o[e] = en_i && hit;
  end

  assert_bw_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_bw_o));
  assert_rank_upper_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_mode_i |-> (inc_bw_o[NUM_BW-1:NUM_RANK] == '0));
  assert_gate_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (inc_bw_o == '0 && inc_rt_o == '0 && inc_ev_o == '0));
  assert_no_acc_no_bw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> (inc_bw_o == '0));
endmodule

// File: rtl/ddr_subch_perf_mon.sv
module ddr_subch_perf_mon
  import ddr_pm_pkg::*;
#(
  parameter int RANK_W    = 2,
  parameter int BG_W      = 3,
  parameter int NUM_RETRY = 10,
  parameter int NUM_EVT   = 16,
  parameter int CNT_W     = 32,
  parameter int CYC_W     = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  logic [RANK_W-1:0]    acc_rank_i,
  input  logic [BG_W-1:0]      acc_bg_i,
  input  logic [NUM_RETRY-1:0] retry_i,
  input  logic                 host_rd_i,
  input  logic                 host_wr_i,
  input  logic                 host_rmw_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o
);
  localparam int NUM_BW = 1 << BG_W;
  localparam int HW     = CYC_W - DATA_W;

  logic                 en_q, mode_q;
  logic [RANK_W-1:0]    rsel_q;
  logic [2*NUM_EVT-1:0] evsel_q;
  logic                 clr;

  logic [NUM_BW-1:0]    inc_bw, ld_bw, oc_bw, ovf_bw;
  logic [NUM_RETRY-1:0] inc_rt, ld_rt, oc_rt, ovf_rt;
  logic [NUM_EVT-1:0]   inc_ev, ld_ev, oc_ev, ovf_ev;
  logic [CNT_W-1:0]     bw_cnt [NUM_BW];
  logic [CNT_W-1:0]     rt_cnt [NUM_RETRY];
  logic [CNT_W-1:0]     ev_cnt [NUM_EVT];
  logic [CYC_W-1:0]     cyc;
  logic [HW-1:0]        shadow;

  assign clr = reg_we_i && (reg_addr_i == A_CTRL) && reg_wdata_i[CTRL_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      rsel_q  <= '0;
      evsel_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) begin
        en_q   <= reg_wdata_i[CTRL_EN];
        mode_q <= reg_wdata_i[CTRL_MODE];
        rsel_q <= reg_wdata_i[CTRL_RSEL +: RANK_W];
      end
      if (reg_addr_i == A_EVSEL) evsel_q <= reg_wdata_i[2*NUM_EVT-1:0];
    end
  end

  pm_route #(
    .RANK_W(RANK_W), .BG_W(BG_W), .NUM_RETRY(NUM_RETRY), .NUM_EVT(NUM_EVT)
  ) u_route (
    .clk_i, .rst_ni,
    .en_i(en_q), .rank_mode_i(mode_q), .rank_sel_i(rsel_q),
    .acc_i, .acc_rank_i, .acc_bg_i, .retry_i,
    .rd_i(host_rd_i), .wr_i(host_wr_i), .rmw_i(host_rmw_i),
    .evsel_i(evsel_q),
    .inc_bw_o(inc_bw), .inc_rt_o(inc_rt), .inc_ev_o(inc_ev)
  );

  pm_cycle #(.CYC_W(CYC_W), .DW(DATA_W)) u_cycle (
    .clk_i, .rst_ni, .en_i(en_q), .clr_i(clr),
    .ld_lo_i(reg_we_i && reg_addr_i == A_CYC_LO),
    .ld_hi_i(reg_we_i && reg_addr_i == A_CYC_HI),
    .ld_val_i(reg_wdata_i),
    .latch_i(reg_re_i && reg_addr_i == A_CYC_LO),
    .cyc_o(cyc), .shadow_o(shadow)
  );

  for (genvar g = 0; g < NUM_BW; g++) begin : g_bw
    assign ld_bw[g] = reg_we_i && (reg_addr_i == ADDR_W'(A_BW_BASE + g));
    assign oc_bw[g] = reg_we_i && (reg_addr_i == A_OVF_BW) && reg_wdata_i[g];
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(clr), .ld_i(ld_bw[g]),
      .ld_val_i(reg_wdata_i[CNT_W-1:0]), .inc_i(inc_bw[g]),
      .ovf_clr_i(oc_bw[g]), .cnt_o(bw_cnt[g]), .ovf_o(ovf_bw[g])
    );
  end

  for (genvar k = 0; k < NUM_RETRY; k++) begin : g_rt
    assign ld_rt[k] = reg_we_i && (reg_addr_i == ADDR_W'(A_RT_BASE + k));
    assign oc_rt[k] = reg_we_i && (reg_addr_i == A_OVF_RT) && reg_wdata_i[k];
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(clr), .ld_i(ld_rt[k]),
      .ld_val_i(reg_wdata_i[CNT_W-1:0]), .inc_i(inc_rt[k]),
      .ovf_clr_i(oc_rt[k]), .cnt_o(rt_cnt[k]), .ovf_o(ovf_rt[k])
    );
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ev
    assign ld_ev[e] = reg_we_i && (reg_addr_i == ADDR_W'(A_EV_BASE + e));
    assign oc_ev[e] = reg_we_i && (reg_addr_i == A_OVF_EV) && reg_wdata_i[e];
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(clr), .ld_i(ld_ev[e]),
      .ld_val_i(reg_wdata_i[CNT_W-1:0]), .inc_i(inc_ev[e]),
      .ovf_clr_i(oc_ev[e]), .cnt_o(ev_cnt[e]), .ovf_o(ovf_ev[e])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTRL_EN]              = en_q;
        reg_rdata_o[CTRL_MODE]            = mode_q;
        reg_rdata_o[CTRL_RSEL +: RANK_W]  = rsel_q;
      end
      A_CYC_LO: reg_rdata_o = cyc[DATA_W-1:0];
      A_CYC_HI: reg_rdata_o = DATA_W'(shadow);
      A_OVF_BW: reg_rdata_o = DATA_W'(ovf_bw);
      A_OVF_RT: reg_rdata_o = DATA_W'(ovf_rt);
      A_OVF_EV: reg_rdata_o = DATA_W'(ovf_ev);
      A_EVSEL:  reg_rdata_o = DATA_W'(evsel_q);
      default: ;
    endcase
    for (int i = 0; i < NUM_BW; i++)
      if (reg_addr_i == ADDR_W'(A_BW_BASE + i)) reg_rdata_o = DATA_W'(bw_cnt[i]);
    for (int i = 0; i < NUM_RETRY; i++)
      if (reg_addr_i == ADDR_W'(A_RT_BASE + i)) reg_rdata_o = DATA_W'(rt_cnt[i]);
    for (int i = 0; i < NUM_EVT; i++)
      if (reg_addr_i == ADDR_W'(A_EV_BASE + i)) reg_rdata_o = DATA_W'(ev_cnt[i]);
  end

  assert_ctrl_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CTRL) |=> (en_q == $past(reg_wdata_i[CTRL_EN])));
endmodule

// File: tb/ddr_subch_perf_mon_bench.sv
module ddr_subch_perf_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc = 1'b0;
  logic [1:0]  acc_rank = '0;
  logic [2:0]  acc_bg = '0;
  logic [9:0]  retry = '0;
  logic        hrd = 1'b0, hwr = 1'b0, hrmw = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int unsigned bw_m [8];
  int unsigned rt_m [10];
  int unsigned ev_m [16];
  bit [1:0]    sel_m [16];
  bit          en_m = 1'b0, mode_m = 1'b0;
  int          rsel_m = 0;

  always #5 clk = ~clk;

  ddr_subch_perf_mon u_ddr_subch_perf_mon (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .acc_rank_i(acc_rank),
    .acc_bg_i(acc_bg), .retry_i(retry), .host_rd_i(hrd), .host_wr_i(hwr),
    .host_rmw_i(hrmw), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic set_ctrl(bit en, bit mode, int rsel);
    en_m = en; mode_m = mode; rsel_m = rsel;
    wr(8'h00, {26'd0, 2'(rsel), 2'd0, mode, en});
  endtask

  task automatic set_sel(logic [31:0] v);
    for (int j = 0; j < 16; j++) sel_m[j] = v[2*j +: 2];
    wr(8'h06, v);
  endtask

  function automatic int bw_target(int rk, int bg);
    if (!mode_m) return (rk == rsel_m) ? bg : -1;
    return rk;
  endfunction

  function automatic bit ev_hit(bit [1:0] s, bit r, bit w, bit m);
    return (s == 2'd1 && r) || (s == 2'd2 && w) || (s == 2'd3 && m);
  endfunction

  task automatic model_step(bit a, int rk, int bg, bit [9:0] rt, bit r, bit w, bit m);
    if (!en_m) return;
    if (a && bw_target(rk, bg) >= 0) bw_m[bw_target(rk, bg)]++;
    for (int k = 0; k < 10; k++) if (rt[k]) rt_m[k]++;
    for (int j = 0; j < 16; j++) if (ev_hit(sel_m[j], r, w, m)) ev_m[j]++;
  endtask

  task automatic step(bit a, int rk, int bg, bit [9:0] rt, bit r, bit w, bit m);
    @(negedge clk);
    acc = a; acc_rank = 2'(rk); acc_bg = 3'(bg); retry = rt;
    hrd = r; hwr = w; hrmw = m;
    @(posedge clk); #1;
    acc = 1'b0; retry = '0; hrd = 1'b0; hwr = 1'b0; hrmw = 1'b0;
    model_step(a, rk, bg, rt, r, w, m);
  endtask

  task automatic zero_model();
    for (int i = 0; i < 8; i++)  bw_m[i] = 0;
    for (int i = 0; i < 10; i++) rt_m[i] = 0;
    for (int i = 0; i < 16; i++) ev_m[i] = 0;
  endtask

  task automatic chk_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 8; i++)  begin rd(8'(8'h10 + i), v); chk(req, v, bw_m[i]); end
    for (int i = 0; i < 10; i++) begin rd(8'(8'h20 + i), v); chk(req, v, rt_m[i]); end
    for (int i = 0; i < 16; i++) begin rd(8'(8'h30 + i), v); chk(req, v, ev_m[i]); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, a, b;
    zero_model();
    for (int j = 0; j < 16; j++) sel_m[j] = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h01, v); chk("R1 cyc_lo", v, 0);
    rd(8'h02, v); chk("R1 cyc_hi", v, 0);
    rd(8'h03, v); chk("R1 ovf_bw", v, 0);
    rd(8'h04, v); chk("R1 ovf_rt", v, 0);
    rd(8'h05, v); chk("R1 ovf_ev", v, 0);
    rd(8'h06, v); chk("R1 evsel", v, 0);
    chk_all("R1 counters");

    // R11 / R3 cycle preload near low wrap
    wr(8'h01, 32'hFFFF_FFFE);
    wr(8'h02, 32'd5);
    set_ctrl(1'b1, 1'b0, 0);
    rd(8'h01, v); chk("R11 cyc_lo preload", v, 32'hFFFF_FFFE);
    repeat (4) @(negedge clk);
    rd(8'h02, v); chk("R3 shadow held", v, 32'd5);
    rd(8'h01, v);
    rd(8'h02, v); chk("R3 shadow after wrap", v, 32'd6);

    // R2 steady stepping
    rd(8'h01, a); rd(8'h01, b); chk("R2 step one", b - a, 32'd1);
    rd(8'h01, a); repeat (5) @(negedge clk); rd(8'h01, b);
    chk("R2 step six", b - a, 32'd6);

    // R8 cycle counter frozen
    set_ctrl(1'b0, 1'b0, 0);
    rd(8'h01, a); repeat (3) @(negedge clk); rd(8'h01, b);
    chk("R8 cycle frozen", b, a);

    // R9 clear zeroes the cycle counter
    wr(8'h00, 32'h8000_0000);
    rd(8'h01, v); chk("R9 cyc_lo clear", v, 0);
    rd(8'h02, v); chk("R9 cyc_hi clear", v, 0);

    // R4 bank-group mode, rank 2
    set_ctrl(1'b1, 1'b0, 2);
    set_sel(32'h0000_0039);
    step(1, 2, 5, '0, 0, 0, 0);
    rd(8'h15, v); chk("R4 bg5 rank2", v, 1);
    step(1, 1, 3, '0, 0, 0, 0);
    step(1, 2, 0, '0, 0, 0, 0);
    chk_all("R4 bank-group");

    // R5 rank mode
    set_ctrl(1'b1, 1'b1, 2);
    step(1, 3, 7, '0, 0, 0, 0);
    step(1, 0, 6, '0, 0, 0, 0);
    rd(8'h13, v); chk("R5 rank3", v, 1);
    rd(8'h17, v); chk("R5 bw7 untouched", v, 0);
    chk_all("R5 rank");

    // R6 retry types
    step(0, 0, 0, 10'h201, 0, 0, 0);
    step(0, 0, 0, 10'h010, 0, 0, 0);
    chk_all("R6 retry");

    // R7 event selection
    step(0, 0, 0, '0, 1, 1, 1);
    step(0, 0, 0, '0, 1, 0, 0);
    step(0, 0, 0, '0, 0, 0, 1);
    rd(8'h30, v); chk("R7 rd sel", v, 2);
    rd(8'h32, v); chk("R7 rmw sel", v, 2);
    rd(8'h33, v); chk("R7 off sel", v, 0);
    chk_all("R7 events");

    // R11 counter preload
    wr(8'h35, 32'h0000_1234); ev_m[5] = 32'h1234;
    wr(8'h21, 32'h0000_0077); rt_m[1] = 32'h77;
    chk_all("R11 preload");

    // R10 wrap and sticky flag
    wr(8'h30, 32'hFFFF_FFFF); ev_m[0] = 32'hFFFF_FFFF;
    step(0, 0, 0, '0, 1, 0, 0);
    rd(8'h30, v); chk("R10 wrap value", v, 0);
    rd(8'h05, v); chk("R10 flag set", v, 32'h1);
    step(0, 0, 0, '0, 1, 0, 0);
    rd(8'h05, v); chk("R10 flag sticky", v, 32'h1);
    wr(8'h30, 32'hFFFF_FFFF); ev_m[0] = 32'hFFFF_FFFF;
    @(negedge clk);
    we = 1'b1; addr = 8'h05; wdata = 32'h1; hrd = 1'b1;
    @(posedge clk); #1 we = 1'b0; hrd = 1'b0;
    model_step(0, 0, 0, '0, 1, 0, 0);
    rd(8'h05, v); chk("R10 set beats clear", v, 32'h1);
    wr(8'h05, 32'h1);
    rd(8'h05, v); chk("R10 w1c", v, 0);
    rd(8'h03, v); chk("R10 bw flags", v, 0);

    // R9 clear races an event strobe
    @(negedge clk);
    we = 1'b1; addr = 8'h00; wdata = 32'h8000_0023; hrd = 1'b1; acc = 1'b1;
    acc_rank = 2'd2; retry = 10'h3;
    @(posedge clk); #1 we = 1'b0; hrd = 1'b0; acc = 1'b0; retry = '0;
    zero_model();
    rd(8'h00, v); chk("R9 ctrl kept", v, 32'h23);
    chk_all("R9 clear wins");

    // random mix, R4 R5 R6 R7
    void'($urandom(32'd4242));
    for (int blk = 0; blk < 4; blk++) begin
      set_ctrl(1'b1, 1'($urandom), int'($urandom % 4));
      set_sel($urandom);
      for (int n = 0; n < 100; n++) begin
        step(1'($urandom % 3 != 0), int'($urandom % 4), int'($urandom % 8),
             10'($urandom & $urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      chk_all("R4 R5 R6 R7 random");
    end

    // R8 enable off gates everything
    set_ctrl(1'b0, 1'b0, 0);
    for (int n = 0; n < 20; n++)
      step(1, int'($urandom % 4), int'($urandom % 8), 10'($urandom), 1, 1, 1);
    chk_all("R8 disabled");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule